// File: doc/BRIEF.md
# One-Hot Washer Cycle Controller with Synchronized Reset

This block sequences a dish-washing cycle through five phases held in a one-hot register: idle (cycle complete), water fill, rinse, drain and dry. After a start request, the machine leaves idle and enters fill. Each working phase then moves to the next one when its own step-complete input is high. Dry returns the machine to idle. Timers and actuators belong to neighbouring logic, which reads the phase bits and drives the completion inputs. The completion inputs are synchronous to `clk`.

The raw active-low reset comes from an analogue network and may be released at any point in a clock period. It passes through a chain of flip-flops on the system clock. The output of that chain is the only reset the phase register sees, and it acts synchronously. As a result, every phase flip-flop leaves reset on the same edge. Idle and fill can never both be set when reset is released with start already high.

The start request comes from an unrelated domain. It passes through its own two-stage synchronizer, which is cleared while the synchronized reset is active.

Top module: `wash_seq_ctrl`

## Requirements
- R1: When `rst_raw_n` is sampled low on a rising edge, `phase_oh` reads `5'b10000` (idle, bit 4) after RST_STAGES+1 rising edges and stays there while reset is low. This holds whatever the other inputs do.
- R2: Once the first synchronized reset has taken effect, exactly one bit of `phase_oh` is 1 on every cycle. This includes cycles around a reset release at any offset from the clock edge.
- R3: Reset release is synchronous. Suppose `start_req` is held high and `rst_raw_n` rises anywhere between two edges. Then `phase_oh` stays `5'b10000` until the fifth rising edge after the rise (RST_STAGES+START_STAGES+1). On that edge it becomes `5'b00001` (fill).
- R4: In idle, `start_req` high moves the machine to fill START_STAGES+1 rising edges after it is first sampled. While `start_req` stays low, the machine stays idle.
- R5: Each working phase advances on the edge where its own completion input is high: fill (bit 0) on `fill_ok` to rinse (bit 1), rinse on `rinse_ok` to drain (bit 2), drain on `drain_ok` to dry (bit 3), and dry on `dry_ok` to idle (bit 4). Without its completion input, a phase holds.
- R6: A completion input that does not belong to the current phase has no effect on `phase_oh`.
- R7: `start_req` has no effect outside the idle phase.
- R8: A reset pulse of one sampled cycle, given in the middle of a cycle, forces idle RST_STAGES+1 edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_raw_n | input | 1 | Raw active-low reset, asynchronous to clk |
| start_req | input | 1 | Start request, asynchronous to clk |
| fill_ok | input | 1 | Water fill complete |
| rinse_ok | input | 1 | Rinse complete |
| drain_ok | input | 1 | Drain complete |
| dry_ok | input | 1 | Dry complete |
| phase_oh | output | 5 | One-hot phase: bit0 fill, bit1 rinse, bit2 drain, bit3 dry, bit4 idle |

## Verification
The main corner case is a reset release at random offsets inside the clock period while start is already high. A design that applied the raw reset directly to the phase flip-flops could enter fill one edge early, or hold idle and fill together. The bench therefore counts the exact edge at which fill appears and checks the one-hot property on every cycle. Other directed cases assert every completion input other than the current one, together with start, during a working phase. A decoder that used the wrong predecessor, or let start act outside idle, would then skip phases. A long random run with occasional short reset pulses compares every cycle against a bench model, which catches a wrong synchronizer depth or a missing start-pipeline clear.

// File: rtl/washer_pkg.sv
package washer_pkg;

    localparam int N_PHASE = 5;

    localparam int PH_FILL  = 0;
    localparam int PH_RINSE = 1;
    localparam int PH_DRAIN = 2;
    localparam int PH_DRY   = 3;
    localparam int PH_IDLE  = 4;

    typedef logic [N_PHASE-1:0] phase_vec_t;

    localparam phase_vec_t IDLE_OH = phase_vec_t'(1) << PH_IDLE;
    localparam phase_vec_t FILL_OH = phase_vec_t'(1) << PH_FILL;

    typedef struct packed {
        phase_vec_t phase;
    } ring_state_t;

endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
    parameter int STAGES  = 2,
    parameter bit CLR_EN  = 1'b0,
    parameter bit CLR_VAL = 1'b0
) (
    input  logic clk,
    input  logic clr_n,
    input  logic d,
    output logic q
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.chain = (sync_q.chain << 1) | STAGES'(d);
        if (CLR_EN && !clr_n) begin
            sync_d.chain = {STAGES{CLR_VAL}};
        end
    end

    always_ff @(posedge clk) begin
        sync_q <= sync_d;
    end

    assign q = sync_q.chain[STAGES-1];

endmodule

// File: rtl/seq_ring.sv
module seq_ring
    import washer_pkg::*;
(
    input  logic       clk,
    input  logic       srst_n,
    input  logic       go,
    input  logic [3:0] step_ok,
    output phase_vec_t phase_oh
);

    ring_state_t ring_d, ring_q;
    phase_vec_t  adv;

    assign adv = {go, step_ok};

    always_comb begin
        ring_d = ring_q;
        for (int i = 0; i < N_PHASE; i++) begin
            ring_d.phase[i] = (ring_q.phase[i] & ~adv[i])
                            | (ring_q.phase[(i + N_PHASE - 1) % N_PHASE]
                               & adv[(i + N_PHASE - 1) % N_PHASE]);
        end
        if (!srst_n) begin
            ring_d.phase = IDLE_OH;
        end
    end

    always_ff @(posedge clk) begin
        ring_q <= ring_d;
    end

    assign phase_oh = ring_q.phase;

    // R2: one phase only, every cycle out of reset
    p_onehot_r2: assert property (@(posedge clk) disable iff (!srst_n)
        $onehot(ring_q.phase));

    // R6: fill ignores every input but its own completion
    p_fill_hold_r6: assert property (@(posedge clk) disable iff (!srst_n)
        (ring_q.phase[PH_FILL] && !step_ok[PH_FILL]) |=> ring_q.phase[PH_FILL]);

    // R5: dry completes back to idle
    p_dry_done_r5: assert property (@(posedge clk) disable iff (!srst_n)
        (ring_q.phase[PH_DRY] && step_ok[PH_DRY]) |=> ring_q.phase[PH_IDLE]);

    // R5: drain advances to dry
    p_drain_next_r5: assert property (@(posedge clk) disable iff (!srst_n)
        (ring_q.phase[PH_DRAIN] && step_ok[PH_DRAIN]) |=> ring_q.phase[PH_DRY]);

endmodule

// File: rtl/wash_seq_ctrl.sv
module wash_seq_ctrl
    import washer_pkg::*;
#(
    parameter int RST_STAGES   = 2,
    parameter int START_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_raw_n,
    input  logic       start_req,
    input  logic       fill_ok,
    input  logic       rinse_ok,
    input  logic       drain_ok,
    input  logic       dry_ok,
    output logic [4:0] phase_oh
);

    logic srst_n;
    logic start_s;
    phase_vec_t ring_phase;

    seq_sync #(
        .STAGES (RST_STAGES),
        .CLR_EN (1'b0),
        .CLR_VAL(1'b0)
    ) u_rst_sync (
        .clk  (clk),
        .clr_n(1'b1),
        .d    (rst_raw_n),
        .q    (srst_n)
    );

    seq_sync #(
        .STAGES (START_STAGES),
        .CLR_EN (1'b1),
        .CLR_VAL(1'b0)
    ) u_start_sync (
        .clk  (clk),
        .clr_n(srst_n),
        .d    (start_req),
        .q    (start_s)
    );

    seq_ring u_ring (
        .clk     (clk),
        .srst_n  (srst_n),
        .go      (start_s),
        .step_ok ({dry_ok, drain_ok, rinse_ok, fill_ok}),
        .phase_oh(ring_phase)
    );

    assign phase_oh = ring_phase;

    // R1: synchronized reset lands the ring in idle on the next edge
    p_rst_idle_r1: assert property (@(posedge clk)
        !srst_n |=> (phase_oh == IDLE_OH));

    // R4: synchronized start leaves idle for fill
    p_start_go_r4: assert property (@(posedge clk) disable iff (!srst_n)
        (phase_oh == IDLE_OH && start_s) |=> (phase_oh == FILL_OH));

    // R4: idle holds without start
    p_start_wait_r4: assert property (@(posedge clk) disable iff (!srst_n)
        (phase_oh == IDLE_OH && !start_s) |=> (phase_oh == IDLE_OH));

endmodule

// File: tb/tb_wash_seq_ctrl.sv
module tb_wash_seq_ctrl;

    localparam int RST_ST = 2;
    localparam int ST_ST  = 2;

    logic clk = 1'b0;
    logic rst_raw_n = 1'b0;
    logic start_req = 1'b0;
    logic fill_ok = 1'b0, rinse_ok = 1'b0, drain_ok = 1'b0, dry_ok = 1'b0;
    logic [4:0] phase_oh;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    wash_seq_ctrl #(.RST_STAGES(RST_ST), .START_STAGES(ST_ST)) dut (
        .clk(clk), .rst_raw_n(rst_raw_n), .start_req(start_req),
        .fill_ok(fill_ok), .rinse_ok(rinse_ok), .drain_ok(drain_ok),
        .dry_ok(dry_ok), .phase_oh(phase_oh)
    );

    always #10 clk = ~clk;

    // bench reference model derived from the requirements
    logic [4:0]        m_state = 5'b10000;
    logic [RST_ST-1:0] m_r = '1;
    logic [ST_ST-1:0]  m_s = '0;
    logic              m_valid = 1'b0;

    function automatic logic [4:0] ref_next(input logic [4:0] cur, input logic rs,
                                            input logic st, input logic [3:0] ok);
        if (!rs) return 5'b10000;
        case (cur)
            5'b10000: return st    ? 5'b00001 : cur;
            5'b00001: return ok[0] ? 5'b00010 : cur;
            5'b00010: return ok[1] ? 5'b00100 : cur;
            5'b00100: return ok[2] ? 5'b01000 : cur;
            5'b01000: return ok[3] ? 5'b10000 : cur;
            default:  return cur;
        endcase
    endfunction

    always @(posedge clk) begin
        m_state <= ref_next(m_state, m_r[RST_ST-1], m_s[ST_ST-1],
                            {dry_ok, drain_ok, rinse_ok, fill_ok});
        if (!m_r[RST_ST-1]) m_valid <= 1'b1;
        m_r <= {m_r[RST_ST-2:0], rst_raw_n};
        m_s <= m_r[RST_ST-1] ? {m_s[ST_ST-2:0], start_req} : '0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // every-cycle checks: R2 one-hot and model agreement
    always @(negedge clk) begin
        if (m_valid) begin
            chk($countones(phase_oh) == 1, "R2 one-hot", phase_oh, m_state);
            chk(phase_oh == m_state, "R5 model", phase_oh, m_state);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog R2 actual %0d expected below 150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_ok();
        fill_ok = 0; rinse_ok = 0; drain_ok = 0; dry_ok = 0;
    endtask

    // pulse one completion input for one edge and check the new phase (R5)
    task automatic step(input int idx, input logic [4:0] exp);
        clear_ok();
        case (idx)
            0: fill_ok = 1;
            1: rinse_ok = 1;
            2: drain_ok = 1;
            default: dry_ok = 1;
        endcase
        tick(1);
        clear_ok();
        chk(phase_oh == exp, "R5 advance", phase_oh, exp);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        tick(RST_ST + 2);
        chk(phase_oh == 5'b10000, "R1 reset idle", phase_oh, 5'b10000);

        // release, start low: stays idle (R4)
        #3 rst_raw_n = 1'b1;
        tick(8);
        chk(phase_oh == 5'b10000, "R4 idle without start", phase_oh, 5'b10000);

        // start latency R4
        begin
            int seen = 0;
            start_req = 1'b1;
            for (int n = 1; n <= 6; n++) begin
                tick(1);
                if (seen == 0 && phase_oh == 5'b00001) seen = n;
            end
            chk(seen == ST_ST + 1, "R4 start latency", seen, ST_ST + 1);
        end

        // in fill: start and foreign completions ignored (R6, R7)
        start_req = 1'b1; rinse_ok = 1; drain_ok = 1; dry_ok = 1;
        tick(3);
        chk(phase_oh == 5'b00001, "R6 R7 fill holds", phase_oh, 5'b00001);
        start_req = 1'b0;
        step(0, 5'b00010);
        fill_ok = 1; drain_ok = 1; dry_ok = 1; tick(2); clear_ok();
        chk(phase_oh == 5'b00010, "R6 rinse holds", phase_oh, 5'b00010);
        step(1, 5'b00100);
        tick(2);
        chk(phase_oh == 5'b00100, "R5 drain holds", phase_oh, 5'b00100);

        // mid-cycle one-cycle reset pulse (R8)
        rst_raw_n = 1'b0; tick(1); rst_raw_n = 1'b1;
        tick(RST_ST - 1);
        chk(phase_oh == 5'b00100, "R8 before reset lands", phase_oh, 5'b00100);
        tick(1);
        chk(phase_oh == 5'b10000, "R8 reset lands", phase_oh, 5'b10000);

        // full pass through dry back to idle (R5)
        start_req = 1'b1; tick(ST_ST + 2); start_req = 1'b0;
        chk(phase_oh == 5'b00001, "R4 restart", phase_oh, 5'b00001);
        step(0, 5'b00010);
        step(1, 5'b00100);
        step(2, 5'b01000);
        start_req = 1'b1; fill_ok = 1; tick(2); clear_ok(); start_req = 1'b0;
        chk(phase_oh == 5'b01000, "R7 dry holds", phase_oh, 5'b01000);
        step(3, 5'b10000);

        // reset release at random offsets with start high (R3)
        for (int t = 0; t < 20; t++) begin
            int seen = 0;
            start_req = 1'b1;
            rst_raw_n = 1'b0;
            tick(RST_ST + 2);
            chk(phase_oh == 5'b10000, "R1 held reset", phase_oh, 5'b10000);
            #($urandom_range(1, 9)) rst_raw_n = 1'b1;
            for (int n = 1; n <= 8; n++) begin
                tick(1);
                if (seen == 0 && phase_oh != 5'b10000) seen = n;
            end
            chk(seen == RST_ST + ST_ST + 1, "R3 release edge", seen, RST_ST + ST_ST + 1);
        end

        // random run with occasional reset pulses, model-checked
        for (int c = 0; c < 4000; c++) begin
            start_req = ($urandom_range(0, 3) == 0);
            fill_ok   = ($urandom_range(0, 2) == 0);
            rinse_ok  = ($urandom_range(0, 2) == 0);
            drain_ok  = ($urandom_range(0, 2) == 0);
            dry_ok    = ($urandom_range(0, 2) == 0);
            rst_raw_n = ($urandom_range(0, 60) != 0);
            tick(1);
        end
        rst_raw_n = 1'b1;
        clear_ok();
        tick(4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule